// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block is the digital control of an 8-bit successive-approximation converter. A start request takes the channel number offered on the select input and holds it on the multiplexer output for the whole conversion. The block opens a sample window of fixed length and then holds the input. It then runs one bit trial per clock, from the most significant bit down. Each trial presents a code to an external resistor-ladder DAC and reads one comparator bit.

When the last bit is decided, the finished code is copied into a result register. A one-cycle end-of-conversion interrupt fires in the same cycle. The result register keeps that value until the next conversion completes. The input multiplexer, the sample/hold stage, the resistor string and the comparator are all outside the block.

All pins are plain control and status signals, so there is no back-pressure. A start is taken only when the block is idle. A start seen while `busy_o` is high is dropped, and the requester must wait for `busy_o` to fall.

Top module: `sar_adc_ctrl`

## Requirements
- R1: A start accepted while idle loads `chan_sel_i` into `chan_o` on the next cycle. `chan_o` then keeps that value until the next accepted start, however `chan_sel_i` moves.
- R2: `sh_sample_o` is 1 for exactly SAMPLE_CYC cycles (default 4), beginning in the cycle after the accepted start. A value of 1 means sample and 0 means hold.
- R3: After the sample window, `sh_sample_o` stays 0 (hold) for all bit trials. The first trial presents `trial_code_o` = 8'h80.
- R4: During the trial of bit b, `trial_code_o` carries the bits already decided above b, then a 1 at bit b, then zeros below b.
- R5: At the end of the trial for bit b, bit b is kept at 1 if `cmp_i` is 1 (input at or above the tap). It is cleared to 0 if `cmp_i` is 0.
- R6: Exactly 8 trials of one cycle each are made. The edge that closes the bit 0 trial loads the decided code into `result_o`.
- R7: `eoc_irq_o` is high for exactly one cycle, and that is the cycle in which `result_o` first shows the new code.
- R8: `result_o` is 0 after reset. It changes only when a conversion completes.
- R9: `busy_o` rises in the cycle after an accepted start. It stays high through the last trial and is low in the cycle `eoc_irq_o` is high.
- R10: A start request while `busy_o` is high has no effect on the trials, the channel or the result.
- R11: After reset, `busy_o`, `sh_sample_o`, `eoc_irq_o`, `trial_code_o` and `result_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion start request, taken when idle |
| chan_sel_i | input | CH_W (3) | Channel to convert |
| cmp_i | input | 1 | Comparator: 1 when the held input is at or above the DAC tap |
| chan_o | output | CH_W (3) | Channel driven to the input multiplexer |
| sh_sample_o | output | 1 | 1 = sample, 0 = hold |
| trial_code_o | output | NBITS (8) | Code that selects the ladder tap |
| busy_o | output | 1 | Conversion in progress |
| result_o | output | NBITS (8) | Last completed conversion code |
| eoc_irq_o | output | 1 | End-of-conversion pulse |

## Verification
The bench converts every code from 0 to 255 and also runs random channel and value pairs, all against an ideal comparator fed from a modelled sample/hold. The two end codes, 0 and 255, catch a sequencer that stops one trial early or forgets to fold in the bit 0 decision; either fault shows up as a wrong least significant bit. Some conversions change the analog value, switch the channel select and pulse start partway through the trials. A design that tracked the input instead of holding it would return the new value, one that re-read the select would move `chan_o`, and one that accepted the late start would restart the trial sequence. The sample window is counted cycle by cycle, and the interrupt is checked for a single-cycle width with `result_o` stable on either side of it, so an off-by-one counter or a sticky interrupt is reported.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_CONV   = 2'd2
  } sar_state_e;
endpackage

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
  import sar_pkg::*;
#(
  parameter int SAMPLE_CYC = 4,
  parameter int NBITS      = 8,
  localparam int IDX_W     = (NBITS > 1) ? $clog2(NBITS) : 1,
  localparam int CNT_W     = (SAMPLE_CYC > 1) ? $clog2(SAMPLE_CYC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             accept_o,
  output logic             init_o,
  output logic             step_o,
  output logic             last_o,
  output logic [IDX_W-1:0] bit_idx_o,
  output logic             sample_o,
  output logic             busy_o
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SAMPLE_CYC - 1);
  localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(NBITS - 1);

  sar_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_SAMPLE;
            cnt_q   <= '0;
          end
        end
        ST_SAMPLE: begin
          if (cnt_q == LAST_CNT) begin
            state_q <= ST_CONV;
            idx_q   <= TOP_IDX;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_CONV: begin
          if (idx_q == '0) state_q <= ST_IDLE;
          else             idx_q   <= idx_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    accept_o  = (state_q == ST_IDLE) && start_i;
    init_o    = (state_q == ST_SAMPLE) && (cnt_q == LAST_CNT);
    step_o    = (state_q == ST_CONV);
    last_o    = (state_q == ST_CONV) && (idx_q == '0);
    sample_o  = (state_q == ST_SAMPLE);
    busy_o    = (state_q != ST_IDLE);
    bit_idx_o = idx_q;
  end
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
  parameter int NBITS  = 8,
  localparam int IDX_W = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic             step_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  input  logic             cmp_i,
  output logic [NBITS-1:0] sar_o,
  output logic [NBITS-1:0] final_o
);
  logic [NBITS-1:0] sar_q;

  // One flop per bit: a bit takes the comparator decision when it is under
  // test, and turns on when the bit directly above it is being decided.
  for (genvar g = 0; g < NBITS; g++) begin : g_bit
    localparam logic [IDX_W-1:0] SELF  = IDX_W'(g);
    localparam logic [IDX_W-1:0] ABOVE = IDX_W'((g + 1) % NBITS);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sar_q[g] <= 1'b0;
      end else if (init_i) begin
        sar_q[g] <= (g == NBITS - 1);
      end else if (step_i) begin
        if (bit_idx_i == SELF)
          sar_q[g] <= cmp_i;
        else if ((g != NBITS - 1) && (bit_idx_i == ABOVE))
          sar_q[g] <= 1'b1;
      end
    end
  end

  always_comb begin
    sar_o   = sar_q;
    final_o = sar_q;
    final_o[0] = cmp_i;
  end
endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [NBITS-1:0] code_i,
  output logic [NBITS-1:0] result_o,
  output logic             irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o <= '0;
      irq_o    <= 1'b0;
    end else begin
      irq_o <= load_i;
      if (load_i) result_o <= code_i;
    end
  end
endmodule

// File: rtl/sar_chan_latch.sv
module sar_chan_latch #(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept_i,
  input  logic [CH_W-1:0] chan_sel_i,
  output logic [CH_W-1:0] chan_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chan_o <= '0;
    else if (accept_i) chan_o <= chan_sel_i;
  end
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int NUM_CH     = 8,
  parameter int NBITS      = 8,
  parameter int SAMPLE_CYC = 4,
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int IDX_W     = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CH_W-1:0]  chan_sel_i,
  input  logic             cmp_i,
  output logic [CH_W-1:0]  chan_o,
  output logic             sh_sample_o,
  output logic [NBITS-1:0] trial_code_o,
  output logic             busy_o,
  output logic [NBITS-1:0] result_o,
  output logic             eoc_irq_o
);
  logic             accept, init, step, last;
  logic [IDX_W-1:0] bit_idx;
  logic [NBITS-1:0] final_code;

  sar_seq_fsm #(.SAMPLE_CYC(SAMPLE_CYC), .NBITS(NBITS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .accept_o(accept), .init_o(init), .step_o(step), .last_o(last),
    .bit_idx_o(bit_idx), .sample_o(sh_sample_o), .busy_o(busy_o)
  );

  sar_approx_reg #(.NBITS(NBITS)) u_sar (
    .clk(clk), .rst_n(rst_n), .init_i(init), .step_i(step),
    .bit_idx_i(bit_idx), .cmp_i(cmp_i),
    .sar_o(trial_code_o), .final_o(final_code)
  );

  sar_result_reg #(.NBITS(NBITS)) u_res (
    .clk(clk), .rst_n(rst_n), .load_i(last), .code_i(final_code),
    .result_o(result_o), .irq_o(eoc_irq_o)
  );

  sar_chan_latch #(.CH_W(CH_W)) u_chan (
    .clk(clk), .rst_n(rst_n), .accept_i(accept),
    .chan_sel_i(chan_sel_i), .chan_o(chan_o)
  );
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int NBITS = 8,
  parameter int CH_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_o,
  input logic             sh_sample_o,
  input logic [NBITS-1:0] trial_code_o,
  input logic [NBITS-1:0] result_o,
  input logic             eoc_irq_o,
  input logic [CH_W-1:0]  chan_o
);
  localparam logic [NBITS-1:0] FIRST_TRIAL = {1'b1, {(NBITS-1){1'b0}}};

  a_r3_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !sh_sample_o) |=> !sh_sample_o);

  a_r3_first_trial: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sh_sample_o) |-> (trial_code_o == FIRST_TRIAL));

  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq_o |=> !eoc_irq_o);

  a_r8_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc_irq_o |-> $stable(result_o));

  a_r9_idle_at_irq: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq_o |-> !busy_o);

  a_r1_chan_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(chan_o));
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.NBITS(NBITS), .CH_W(CH_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .sh_sample_o(sh_sample_o),
  .trial_code_o(trial_code_o), .result_o(result_o), .eoc_irq_o(eoc_irq_o),
  .chan_o(chan_o)
);

// File: tb/sar_adc_ctrl_tb_top.sv
`timescale 1ns/1ps
module sar_adc_ctrl_tb_top;
  localparam int NUM_CH = 8;
  localparam int NBITS  = 8;
  localparam int SCYC   = 4;
  localparam int CH_W   = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [CH_W-1:0]  chan_sel_i = '0;
  logic             cmp_i;
  logic [CH_W-1:0]  chan_o;
  logic             sh_sample_o;
  logic [NBITS-1:0] trial_code_o;
  logic             busy_o;
  logic [NBITS-1:0] result_o;
  logic             eoc_irq_o;

  int ana [NUM_CH];
  int held_v = 0;
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  sar_adc_ctrl #(.NUM_CH(NUM_CH), .NBITS(NBITS), .SAMPLE_CYC(SCYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_sel_i(chan_sel_i),
    .cmp_i(cmp_i), .chan_o(chan_o), .sh_sample_o(sh_sample_o),
    .trial_code_o(trial_code_o), .busy_o(busy_o), .result_o(result_o),
    .eoc_irq_o(eoc_irq_o)
  );

  // External analog model: track while sampling, freeze while holding.
  always @(posedge clk) if (sh_sample_o) held_v <= ana[chan_o];
  assign cmp_i = (held_v >= int'(trial_code_o));

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_trial(input int v, input int b);
    return ((v >> (b + 1)) << (b + 1)) | (1 << b);
  endfunction

  task automatic convert(input int ch, input int v, input bit disturb);
    int old_res;
    ana[ch] = v;
    old_res = int'(result_o);
    @(negedge clk);
    chan_sel_i = CH_W'(ch);
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    chk(chan_o == CH_W'(ch), "R1 channel latched", int'(chan_o), ch);
    chk(busy_o == 1'b1, "R9 busy after start", int'(busy_o), 1);
    for (int i = 0; i < SCYC; i++) begin
      chk(sh_sample_o == 1'b1, "R2 sample window", int'(sh_sample_o), 1);
      @(posedge clk); @(negedge clk);
    end
    for (int b = NBITS - 1; b >= 0; b--) begin
      chk(sh_sample_o == 1'b0, "R3 hold during trials", int'(sh_sample_o), 0);
      chk(int'(trial_code_o) == exp_trial(v, b), "R4 R5 trial code",
          int'(trial_code_o), exp_trial(v, b));
      chk(busy_o && !eoc_irq_o && int'(result_o) == old_res, "R8 R9 during trials",
          int'(result_o), old_res);
      if (disturb && b == 4) begin
        start_i = 1'b1;
        chan_sel_i = CH_W'(ch + 1);
        ana[ch] = 255 - v;
      end
      @(posedge clk); @(negedge clk);
      start_i = 1'b0;
      if (disturb && b == 4)
        chk(chan_o == CH_W'(ch), "R1 R10 channel ignores late change", int'(chan_o), ch);
    end
    chk(eoc_irq_o == 1'b1, "R7 irq with result", int'(eoc_irq_o), 1);
    chk(int'(result_o) == v, "R6 result code", int'(result_o), v);
    chk(busy_o == 1'b0, "R9 busy low at irq", int'(busy_o), 0);
    @(posedge clk); @(negedge clk);
    chk(eoc_irq_o == 1'b0, "R7 irq single cycle", int'(eoc_irq_o), 0);
    chk(int'(result_o) == v, "R8 result held", int'(result_o), v);
    chk(busy_o == 1'b0 && sh_sample_o == 1'b0, "R10 no restart from late start",
        int'(busy_o), 0);
    chk(int'(trial_code_o) == v, "R4 final code on trial bus", int'(trial_code_o), v);
  endtask

  initial begin
    int seed;
    seed = 32'h5a3c;
    void'($urandom(seed));
    for (int i = 0; i < NUM_CH; i++) ana[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk(!busy_o && !sh_sample_o && !eoc_irq_o, "R11 reset controls", int'(busy_o), 0);
    chk(trial_code_o == '0, "R11 reset trial code", int'(trial_code_o), 0);
    chk(result_o == '0, "R8 R11 reset result", int'(result_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && result_o == '0, "R11 idle after reset", int'(busy_o), 0);
    // directed corners
    convert(0, 0, 1'b0);
    convert(7, 255, 1'b0);
    convert(3, 128, 1'b1);
    convert(5, 127, 1'b1);
    convert(2, 0, 1'b1);
    convert(6, 255, 1'b1);
    // every code
    for (int v = 0; v < 256; v++) convert(v % NUM_CH, v, v[3]);
    // random mix
    for (int k = 0; k < 80; k++)
      convert(int'($urandom % NUM_CH), int'($urandom % 256), 1'($urandom));
    finish_run();
  end
endmodule